// File: doc/BRIEF.md
# Master Poll and Retry Scheduler

This controller lives in the master node of a shared serial bus on which one master serves a small set of slave nodes, and slaves only ever speak when spoken to. On every periodic scheduling tick (nominally every 512 us) it decides which frame to launch next. A command presented by the host side (halt a slave, write its digital outputs, or write digital plus analog values) always wins. With no command waiting, it polls the next slave with a check frame, but only once the line has been quiet for a guard interval.

Once a frame is handed to the frame assembler, the scheduler waits for the transmission to end and then for the slave's answer. A single timeout, sized to the longest possible transaction, covers both a missing answer and an answer that fails its CRC. When the timeout expires, the same frame is sent again. After a bounded number of retransmissions the transaction is abandoned, and a fault bit for that slave address is set and stays set.

Top module: `mps_poll_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `frame_start`, `xact_done`, `cmd_ack` and every bit of `fault_flags` are 0.
- R2: A tick seen in idle with `cmd_req` high accepts the command. `cmd_ack` is 1 in that same cycle, and in the next cycle `frame_start` rises with `frame_kind` = `cmd_kind` and `frame_addr` = `cmd_addr`. The kind code is 0 = check, 1 = halt, 2 = digital write, 3 = mixed write.
- R3: A tick seen in idle with no command starts a poll. A check frame (kind 0) is raised only after `bus_idle` has been high for GUARD_US consecutive microseconds (GUARD_US*CLK_PER_US clocks). Any cycle with `bus_idle` low restarts the guard.
- R4: Polls visit addresses 0, 1, ..., NUM_PERIPH-1 and then wrap to 0. The poll address advances only when a poll transaction finishes, whether it succeeds or fails. Commands never advance it.
- R5: A command that arrives while a poll is still in its guard interval pre-empts that poll. It is acknowledged and issued at once, and the pre-empted poll address is used by the next poll.
- R6: While `frame_start` is high and `frame_ready` is low, `frame_start`, `frame_kind` and `frame_addr` hold. The cycle after `frame_ready` is seen, `frame_start` is low.
- R7: After `tx_done`, a reply with `reply_valid` and `reply_crc_ok` both high ends the transaction. In the next cycle `xact_done`=1 and `xact_ok`=1, and no retransmission follows.
- R8: A reply with a bad CRC is ignored. If no good reply arrives within TIMEOUT_US microseconds of `tx_done`, the same kind and address are raised again with `frame_retry`=1.
- R9: When the timeout expires after the MAX_RETRY-th retransmission, the scheduler reports `xact_done`=1 with `xact_ok`=0 and sets `fault_flags[addr]`. Fault bits clear only on reset, and at most one bit rises per cycle.
- R10: While a transaction is in flight, ticks and commands are not accepted (`cmd_ack` stays 0). A reply that arrives before `tx_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_tick | input | 1 | One-cycle scheduling pulse (nominal 512 us period) |
| bus_idle | input | 1 | High while the shared line is quiet |
| cmd_req | input | 1 | Host command waiting |
| cmd_kind | input | 2 | Kind of the waiting command |
| cmd_addr | input | AW | Target slave of the waiting command |
| cmd_ack | output | 1 | Command taken this cycle |
| frame_start | output | 1 | Request to the frame assembler |
| frame_kind | output | 2 | Kind of the requested frame |
| frame_addr | output | AW | Slave address of the requested frame |
| frame_retry | output | 1 | Requested frame is a retransmission |
| frame_ready | input | 1 | Frame assembler takes the request |
| tx_done | input | 1 | Transmission of the frame has ended |
| reply_valid | input | 1 | A reply frame has been received |
| reply_crc_ok | input | 1 | The received reply passed its CRC check |
| xact_done | output | 1 | Transaction finished (one-cycle pulse) |
| xact_ok | output | 1 | Finished transaction succeeded |
| fault_flags | output | NUM_PERIPH | Sticky per-address fault bits |

## Verification
Directed transactions come first. One sequence covers every command kind at varied addresses. Polls run with a steady quiet line and with a line that breaks quiet mid-guard, which separates a restarting guard from a free-running one. A command is injected during the guard to show pre-emption, and a run of consecutive polls demonstrates the address wrap. Reply patterns then vary per send: a clean answer, a bad-CRC answer, silence, and an answer that arrives before transmission has ended. These separate acceptance from the timeout path and an early reply from a legal one, and they measure the timeout length. Seeded random transactions finish the run, mixing commands and polls with random per-send outcomes. They reach the retry limit and the fault bits at many addresses, and the bench model predicts every address, retry flag and fault vector.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [1:0] {
        FK_CHECK   = 2'd0,
        FK_HALT    = 2'd1,
        FK_DIGITAL = 2'd2,
        FK_MIXED   = 2'd3
    } frame_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GUARD = 3'd1,
        ST_ISSUE = 3'd2,
        ST_SEND  = 3'd3,
        ST_WAIT  = 3'd4
    } sched_state_e;

    // Descriptor of the transaction currently owned by the scheduler
    typedef struct packed {
        frame_kind_e kind;
        logic        poll;   // originated by the poll walker, not by a command
    } xact_tag_t;

    // The microsecond timer counts only while guarding or waiting
    function automatic logic timer_runs(sched_state_e st);
        return (st == ST_GUARD) || (st == ST_WAIT);
    endfunction

endpackage

// File: rtl/mps_us_timer.sv
module mps_us_timer #(
    parameter int CLK_PER_US = 50,
    parameter int US_W       = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    output logic [US_W-1:0] us_cnt
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q  <= '0;
            us_cnt <= '0;
        end else if (en) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (us_cnt != '1) begin
                    us_cnt <= us_cnt + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mps_poll_ptr.sv
module mps_poll_ptr #(
    parameter int NUM = 8,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(NUM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/mps_fault_bank.sv
module mps_fault_bank #(
    parameter int NUM = 8,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set,
    input  logic [AW-1:0]  set_addr,
    output logic [NUM-1:0] flags
);
    for (genvar g = 0; g < NUM; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (set && (set_addr == AW'(g))) begin
                flags[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mps_poll_sched.sv
module mps_poll_sched
    import mps_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int CLK_PER_US = 50,
    parameter int GUARD_US   = 139,
    parameter int TIMEOUT_US = 8888,
    parameter int MAX_RETRY  = 3,
    localparam int AW = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sched_tick,
    input  logic                  bus_idle,
    input  logic                  cmd_req,
    input  logic [1:0]            cmd_kind,
    input  logic [AW-1:0]         cmd_addr,
    output logic                  cmd_ack,
    output logic                  frame_start,
    output logic [1:0]            frame_kind,
    output logic [AW-1:0]         frame_addr,
    output logic                  frame_retry,
    input  logic                  frame_ready,
    input  logic                  tx_done,
    input  logic                  reply_valid,
    input  logic                  reply_crc_ok,
    output logic                  xact_done,
    output logic                  xact_ok,
    output logic [NUM_PERIPH-1:0] fault_flags
);
    localparam int LIMIT_US = (TIMEOUT_US > GUARD_US) ? TIMEOUT_US : GUARD_US;
    localparam int US_W     = $clog2(LIMIT_US + 1) + 1;
    localparam int RW       = $clog2(MAX_RETRY + 2);
    localparam logic [US_W-1:0] GUARD_LIM = US_W'(GUARD_US);
    localparam logic [US_W-1:0] TOUT_LIM  = US_W'(TIMEOUT_US);
    localparam logic [RW-1:0]   RETRY_LIM = RW'(MAX_RETRY);

    sched_state_e    state_q, state_d;
    xact_tag_t       tag_q;
    logic [AW-1:0]   addr_q;
    logic [RW-1:0]   retry_q;
    logic            done_q, ok_q;

    logic [US_W-1:0] us_cnt;
    logic [AW-1:0]   poll_ptr;
    logic            timer_clr, timer_en;
    logic            accept_cmd, start_poll, guard_met;
    logic            reply_good, expired, do_retry, give_up, finish;

    // ---------------- decisions ----------------
    always_comb begin
        accept_cmd = cmd_req && (((state_q == ST_IDLE) && sched_tick) ||
                                 (state_q == ST_GUARD));
        start_poll = (state_q == ST_IDLE) && sched_tick && !cmd_req;
        guard_met  = (state_q == ST_GUARD) && !cmd_req && bus_idle &&
                     (us_cnt >= GUARD_LIM);
        reply_good = (state_q == ST_WAIT) && reply_valid && reply_crc_ok;
        expired    = (state_q == ST_WAIT) && !reply_good && (us_cnt >= TOUT_LIM);
        do_retry   = expired && (retry_q < RETRY_LIM);
        give_up    = expired && !do_retry;
        finish     = reply_good || give_up;
        timer_en   = timer_runs(state_q);
        timer_clr  = !timer_en || ((state_q == ST_GUARD) && !bus_idle);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_cmd)      state_d = ST_ISSUE;
                else if (start_poll) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (accept_cmd || guard_met) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (frame_ready) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (tx_done) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (finish)        state_d = ST_IDLE;
                else if (do_retry) state_d = ST_ISSUE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state and descriptor ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tag_q   <= '{kind: FK_CHECK, poll: 1'b0};
            addr_q  <= '0;
            retry_q <= '0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            ok_q    <= reply_good;
            if (accept_cmd) begin
                tag_q   <= '{kind: frame_kind_e'(cmd_kind), poll: 1'b0};
                addr_q  <= cmd_addr;
                retry_q <= '0;
            end else if (start_poll) begin
                tag_q   <= '{kind: FK_CHECK, poll: 1'b1};
                addr_q  <= poll_ptr;
                retry_q <= '0;
            end else if (do_retry) begin
                retry_q <= retry_q + 1'b1;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    mps_us_timer #(
        .CLK_PER_US (CLK_PER_US),
        .US_W       (US_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (timer_clr),
        .en     (timer_en),
        .us_cnt (us_cnt)
    );

    mps_poll_ptr #(
        .NUM (NUM_PERIPH),
        .AW  (AW)
    ) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (finish && tag_q.poll),
        .ptr (poll_ptr)
    );

    mps_fault_bank #(
        .NUM (NUM_PERIPH),
        .AW  (AW)
    ) u_faults (
        .clk      (clk),
        .rst      (rst),
        .set      (give_up),
        .set_addr (addr_q),
        .flags    (fault_flags)
    );

    // ---------------- outputs ----------------
    assign cmd_ack     = accept_cmd;
    assign frame_start = (state_q == ST_ISSUE);
    assign frame_kind  = tag_q.kind;
    assign frame_addr  = addr_q;
    assign frame_retry = (retry_q != '0);
    assign xact_done   = done_q;
    assign xact_ok     = ok_q;
endmodule

// File: rtl/mps_poll_sched_chk.sv
module mps_poll_sched_chk #(
    parameter int NUM_PERIPH = 8,
    parameter int AW         = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_req,
    input logic                  cmd_ack,
    input logic                  frame_start,
    input logic [1:0]            frame_kind,
    input logic [AW-1:0]         frame_addr,
    input logic                  frame_ready,
    input logic                  xact_done,
    input logic                  xact_ok,
    input logic [NUM_PERIPH-1:0] fault_flags
);
    // R6: an unaccepted request holds its content
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !frame_ready) |=>
            (frame_start && $stable(frame_kind) && $stable(frame_addr)));

    // R2: an acknowledged command is requested in the next cycle
    assert_ack_issues_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> frame_start);

    // R10: nothing is acknowledged without a waiting command
    assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> cmd_req);

    // R7: completion and a new request never coincide
    assert_done_not_issue_R7: assert property (@(posedge clk) disable iff (rst)
        xact_done |-> !frame_start);

    // R9: fault bits never fall
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(fault_flags) & ~fault_flags) == '0));

    // R9: at most one fault bit rises per cycle
    assert_fault_single_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(fault_flags & ~$past(fault_flags)) <= 1));

    // R9: a fault bit only rises with a failed completion
    assert_fault_on_fail_R9: assert property (@(posedge clk) disable iff (rst)
        (fault_flags != $past(fault_flags)) |-> (xact_done && !xact_ok));
endmodule

bind mps_poll_sched mps_poll_sched_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .AW         (AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_req     (cmd_req),
    .cmd_ack     (cmd_ack),
    .frame_start (frame_start),
    .frame_kind  (frame_kind),
    .frame_addr  (frame_addr),
    .frame_ready (frame_ready),
    .xact_done   (xact_done),
    .xact_ok     (xact_ok),
    .fault_flags (fault_flags)
);

// File: tb/sim_mps_poll_sched.sv
module sim_mps_poll_sched;
    localparam int N  = 8;
    localparam int D  = 2;    // clocks per microsecond
    localparam int G  = 4;    // guard microseconds
    localparam int T  = 30;   // timeout microseconds
    localparam int MR = 3;    // retransmissions allowed

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sched_tick = 1'b0, bus_idle = 1'b1, cmd_req = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic [2:0] cmd_addr = 3'd0;
    logic       cmd_ack, frame_start, frame_retry;
    logic [1:0] frame_kind;
    logic [2:0] frame_addr;
    logic       frame_ready = 1'b0, tx_done = 1'b0;
    logic       reply_valid = 1'b0, reply_crc_ok = 1'b0;
    logic       xact_done, xact_ok;
    logic [N-1:0] fault_flags;

    always #10 clk = ~clk;

    mps_poll_sched #(
        .NUM_PERIPH (N), .CLK_PER_US (D), .GUARD_US (G),
        .TIMEOUT_US (T), .MAX_RETRY (MR)
    ) u0 (
        .clk (clk), .rst (rst), .sched_tick (sched_tick), .bus_idle (bus_idle),
        .cmd_req (cmd_req), .cmd_kind (cmd_kind), .cmd_addr (cmd_addr),
        .cmd_ack (cmd_ack), .frame_start (frame_start), .frame_kind (frame_kind),
        .frame_addr (frame_addr), .frame_retry (frame_retry),
        .frame_ready (frame_ready), .tx_done (tx_done),
        .reply_valid (reply_valid), .reply_crc_ok (reply_crc_ok),
        .xact_done (xact_done), .xact_ok (xact_ok), .fault_flags (fault_flags)
    );

    int       n_chk = 0, n_bad = 0, cyc_total = 0;
    bit       finished = 1'b0;
    int       ptr_m = 0;
    logic [N-1:0] fault_m = '0;

    task automatic chk_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(string req, string what, int act, int lo, int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
            report();
            $finish;
        end
    end

    // wait at negedges until a request or a completion is visible
    task automatic wait_event(output int cyc);
        cyc = 0;
        while (!(frame_start || xact_done) && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pulse_tick(bit exp_ack, string req);
        @(negedge clk);
        sched_tick = 1'b1;
        #1;
        chk_eq(req, "cmd_ack on tick", int'(cmd_ack), int'(exp_ack));
        @(negedge clk);
        sched_tick = 1'b0;
        if (exp_ack) cmd_req = 1'b0;
    endtask

    // one send: outcome 0 good reply, 1 bad-CRC reply, 2 silence
    task automatic serve(int ek, int ea, bit er, int outcome, bit last,
                         bit inject, output int cyc, output bit good);
        int k;
        wait_event(cyc);
        chk_eq("R2", "frame_start raised", int'(frame_start), 1);
        chk_eq("R2", "frame_kind", int'(frame_kind), ek);
        chk_eq("R4", "frame_addr", int'(frame_addr), ea);
        chk_eq("R8", "frame_retry", int'(frame_retry), int'(er));
        repeat (2) @(negedge clk);
        chk_eq("R6", "held start", int'(frame_start), 1);
        chk_eq("R6", "held addr", int'(frame_addr), ea);
        chk_eq("R6", "held kind", int'(frame_kind), ek);
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        chk_eq("R6", "start dropped after ready", int'(frame_start), 0);
        if (inject) begin
            reply_valid = 1'b1; reply_crc_ok = 1'b1;
            @(negedge clk);
            reply_valid = 1'b0; reply_crc_ok = 1'b0;
        end
        repeat (2) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        k = 1;
        good = 1'b0;
        if (outcome == 0) begin
            @(negedge clk);
            reply_valid = 1'b1; reply_crc_ok = 1'b1;
            @(negedge clk);
            reply_valid = 1'b0; reply_crc_ok = 1'b0;
            chk_eq("R7", "xact_done on good reply", int'(xact_done), 1);
            chk_eq("R7", "xact_ok on good reply", int'(xact_ok), 1);
            @(negedge clk);
            chk_eq("R7", "no retransmission", int'(frame_start), 0);
            good = 1'b1;
        end else begin
            if (outcome == 1) begin
                reply_valid = 1'b1; reply_crc_ok = 1'b0;
                @(negedge clk);
                reply_valid = 1'b0;
                k++;
            end
            if (inject) begin
                sched_tick = 1'b1; cmd_req = 1'b1;
                #1;
                chk_eq("R10", "cmd_ack while waiting", int'(cmd_ack), 0);
                @(negedge clk);
                sched_tick = 1'b0; cmd_req = 1'b0;
                k++;
            end
            while (!(frame_start || xact_done) && k < 4000) begin
                @(negedge clk);
                k++;
            end
            chk_rng("R8", "timeout cycles", k, T * D, T * D + 3);
            if (last) begin
                chk_eq("R9", "xact_done at give-up", int'(xact_done), 1);
                chk_eq("R9", "xact_ok at give-up", int'(xact_ok), 0);
            end else begin
                chk_eq("R8", "retransmission raised", int'(frame_start), 1);
                chk_eq("R10", "no completion before retry", int'(xact_done), 0);
            end
        end
    endtask

    // mode: 0 random, 1 good, 2 all fail, 3 bad then good, 4 early reply + silence then good
    task automatic do_xact(bit is_cmd, int kind, int addr, int mode, bit drop_idle);
        int  ea, ek, cyc, outcome;
        bit  good, inj;
        ea = is_cmd ? addr : ptr_m;
        ek = is_cmd ? kind : 0;
        if (is_cmd) begin
            cmd_req = 1'b1; cmd_kind = 2'(kind); cmd_addr = 3'(addr);
            pulse_tick(1'b1, "R2");
        end else begin
            pulse_tick(1'b0, "R3");
            if (drop_idle) begin
                repeat (3) @(negedge clk);
                bus_idle = 1'b0;
                @(negedge clk);
                bus_idle = 1'b1;
            end
        end
        good = 1'b0;
        for (int s = 0; s <= MR; s++) begin
            case (mode)
                1:       outcome = 0;
                2:       outcome = (s % 2 == 0) ? 1 : 2;
                3:       outcome = (s == 0) ? 1 : 0;
                4:       outcome = (s == 0) ? 2 : 0;
                default: outcome = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(1, 2));
            endcase
            inj = (mode == 4) && (s == 0);
            serve(ek, ea, s > 0, outcome, s == MR, inj, cyc, good);
            if (s == 0) begin
                if (is_cmd)
                    chk_eq("R2", "command issued next cycle", cyc, 0);
                else if (drop_idle)
                    chk_rng("R3", "guard restart cycles", cyc + 1 + 4, G * D + 4, G * D + 7);
                else
                    chk_rng("R3", "guard cycles", cyc + 1, G * D, G * D + 3);
            end
            if (good) break;
        end
        if (!good) fault_m[ea] = 1'b1;
        chk_eq("R9", "fault_flags", int'(fault_flags), int'(fault_m));
        if (!is_cmd) ptr_m = (ptr_m + 1) % N;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cyc;
        bit good;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_eq("R1", "frame_start in reset", int'(frame_start), 0);
        chk_eq("R1", "fault_flags in reset", int'(fault_flags), 0);
        chk_eq("R1", "xact_done in reset", int'(xact_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", "frame_start after reset", int'(frame_start), 0);
        chk_eq("R1", "cmd_ack after reset", int'(cmd_ack), 0);

        // plain poll and each command kind
        do_xact(1'b0, 0, 0, 1, 1'b0);
        do_xact(1'b1, 1, 5, 1, 1'b0);
        do_xact(1'b1, 2, 2, 1, 1'b0);
        do_xact(1'b1, 3, 7, 1, 1'b0);
        // guard restarted by a busy line (R3)
        do_xact(1'b0, 0, 0, 1, 1'b1);

        // R5: command pre-empts a poll in its guard
        pulse_tick(1'b0, "R5");
        repeat (2) @(negedge clk);
        cmd_req = 1'b1; cmd_kind = 2'd2; cmd_addr = 3'd6;
        #1;
        chk_eq("R5", "cmd_ack during guard", int'(cmd_ack), 1);
        @(negedge clk);
        cmd_req = 1'b0;
        serve(2, 6, 1'b0, 0, 1'b0, 1'b0, cyc, good);
        chk_eq("R5", "pre-empting command issued", cyc, 0);
        repeat (2) @(negedge clk);
        do_xact(1'b0, 0, 0, 1, 1'b0);   // uses the pre-empted address

        // R8: bad CRC then good; R10: early reply and tick ignored
        do_xact(1'b0, 0, 0, 3, 1'b0);
        do_xact(1'b1, 1, 4, 4, 1'b0);
        // R9: all sends fail on a command and on a poll
        do_xact(1'b1, 3, 3, 2, 1'b0);
        do_xact(1'b0, 0, 0, 2, 1'b0);

        // R4: run the walker past its wrap
        for (int i = 0; i < N + 1; i++) do_xact(1'b0, 0, 0, 1, 1'b0);

        // seeded random mix
        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(0, 1) == 1)
                do_xact(1'b1, int'($urandom_range(1, 3)), int'($urandom_range(0, N - 1)), 0, 1'b0);
            else
                do_xact(1'b0, 0, 0, 0, 1'b0);
        end

        finished = 1'b1;
        report();
        $finish;
    end
endmodule